// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog with Vector-Shared Service Location

This block watches over running software. A prescaler and a timeout counter, both driven from the crystal-derived clock, measure the time since the last service. Software services the watchdog by writing any value to bus address 16'hFFFF. That address also holds the low byte of the reset vector. A read of that address returns the vector byte, and no watchdog state is visible there. If software fails to service in time, the block raises a one-clock reset request to the chip's reset sequencer. The block never raises an interrupt.

A rate-select bit picks a long or a short timeout. Mode inputs control when the watchdog runs. It is switched off in monitor mode when the test high voltage is seen on either the interrupt pin or the reset pin. It is also switched off during a break when the high voltage is seen on the reset pin. In wait mode it keeps counting. In stop mode its clock is gated off: the prescaler is cleared and the counter holds its value.

A controller sequences the block through six states:
- `ST_OFF`: disabled.
- `ST_RUN`: counting.
- `ST_DOZE`: counting while in wait mode.
- `ST_HALT`: stop mode.
- `ST_FIRE`: reset request high.
- `ST_SPENT`: expired, waiting for block reset.

The transitions are:
- Any of the four live states goes to `ST_OFF` when the disable condition holds.
- A live state goes to `ST_HALT` on stop.
- A live state goes to `ST_DOZE` on wait.
- A live state goes to `ST_RUN` otherwise.
- A live state goes to `ST_FIRE` on the final prescaler tick at the limit, when no service arrives in the same cycle.
- `ST_FIRE` always goes to `ST_SPENT`.
- `ST_SPENT` stays there until `rst_n` is asserted.

Top module: `cop_watchdog`

## Requirements
- R1: While `rst_n` is low, `cop_rst_req` is 0. After `rst_n` is released with the block enabled, counting starts from zero at the first clock edge.
- R2: Let P = 2^PRE_W. The timeout is T = LONG_TICKS·P counted edges when `rate_sel`=0, and T = SHORT_TICKS·P counted edges when `rate_sel`=1. `cop_rst_req` is 1 in the cycle after the T-th counted edge that follows a reset release or a service.
- R3: `cop_rst_req` stays high for exactly one clock. It then stays low until the block is reset.
- R4: A write (`bus_wr`=1) with `bus_addr`=16'hFFFF clears both the prescaler and the counter, which starts a full new period. A write to any other address has no effect.
- R5: A read with `bus_addr`=16'hFFFF returns the parameter VEC_LO on `bus_rdata`, whatever the watchdog state and including during reset. Any other address returns 8'h00.
- R6: When `mon_mode`=1 and either `hv_on_irq` or `hv_on_rst` is 1, the prescaler and counter are held at zero and no reset request is raised.
- R7: When `brk_active`=1 and `hv_on_rst`=1, the block is disabled as in R6. `brk_active` together with `hv_on_irq` alone does not disable it.
- R8: `wait_mode` has no effect on the count, and a timeout still raises the request.
- R9: While `stop_mode`=1, the prescaler is cleared and the counter holds its value. Suppose stop begins after k counted edges. Then the request follows T − P·floor(k/P) counted edges after stop ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_addr | input | 16 | CPU bus address |
| bus_wr | input | 1 | CPU write strobe |
| bus_rdata | output | 8 | Read data (vector byte at 16'hFFFF) |
| rate_sel | input | 1 | Timeout select: 0 long, 1 short |
| mon_mode | input | 1 | Monitor mode active |
| brk_active | input | 1 | Break interrupt in progress |
| hv_on_irq | input | 1 | Test high voltage detected on the interrupt pin |
| hv_on_rst | input | 1 | Test high voltage detected on the reset pin |
| stop_mode | input | 1 | Stop mode: clock gated, prescaler cleared |
| wait_mode | input | 1 | Wait mode: counting continues |
| cop_rst_req | output | 1 | One-clock reset request on timeout |

## Verification
The hardest case to reach is a stop entry that falls partway through a prescaler period. The bench must show that the partial prescale is lost while the counter keeps its value. To get there, the bench counts a chosen number of edges that is not a multiple of P and then raises stop for a long stretch. It then predicts the remaining time as T − P·floor(k/P) and checks the request edge by edge. The mode-disable rules are swept over all sixteen combinations of monitor, break and the two high-voltage detects. A timeout is expected exactly where the disable equation is false.

// File: rtl/cop_pkg.sv
package cop_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_RUN,
        ST_DOZE,
        ST_HALT,
        ST_FIRE,
        ST_SPENT
    } cop_state_t;

    localparam logic [15:0] COP_SVC_ADDR = 16'hFFFF;
endpackage

// File: rtl/cop_prescaler.sv
module cop_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [PRE_W-1:0] pre_q,
    output logic             tick
);
    // tick marks the edge on which the prescaler wraps
    assign tick = en && (&pre_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clr)
            pre_q <= '0;
        else if (en)
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/cop_timeout_counter.sv
module cop_timeout_counter #(
    parameter int CNT_W       = 14,
    parameter int LONG_TICKS  = 16383,
    parameter int SHORT_TICKS = 511
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             rate_sel,
    output logic [CNT_W-1:0] cnt_q,
    output logic             last
);
    localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_TICKS - 1);
    localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_TICKS - 1);

    logic [CNT_W-1:0] lim_m1;

    assign lim_m1 = rate_sel ? SHORT_M1 : LONG_M1;
    assign last   = tick && (cnt_q == lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cop_ctrl_fsm.sv
module cop_ctrl_fsm
    import cop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dis,
    input  logic       stop,
    input  logic       doze,
    input  logic       svc,
    input  logic       last,
    output logic       run_en,
    output logic       pre_clr,
    output logic       cnt_clr,
    output logic       req,
    output logic       live,
    output cop_state_t state_o
);
    cop_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF, ST_RUN, ST_DOZE, ST_HALT: begin
                if (dis)
                    state_d = ST_OFF;
                else if (last && !svc)
                    state_d = ST_FIRE;
                else if (stop)
                    state_d = ST_HALT;
                else if (doze)
                    state_d = ST_DOZE;
                else
                    state_d = ST_RUN;
            end
            ST_FIRE:  state_d = ST_SPENT;
            ST_SPENT: state_d = ST_SPENT;
        endcase
    end

    // outputs
    always_comb begin
        live    = (state_q == ST_OFF) || (state_q == ST_RUN) ||
                  (state_q == ST_DOZE) || (state_q == ST_HALT);
        run_en  = live && !dis && !stop;
        pre_clr = !run_en || svc;
        cnt_clr = svc || !live || dis;
        req     = (state_q == ST_FIRE);
        state_o = state_q;
    end
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
    import cop_pkg::*;
#(
    parameter int         PRE_W       = 4,
    parameter int         LONG_TICKS  = 16383,
    parameter int         SHORT_TICKS = 511,
    parameter logic [7:0] VEC_LO      = 8'h80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    output logic [7:0]  bus_rdata,
    input  logic        rate_sel,
    input  logic        mon_mode,
    input  logic        brk_active,
    input  logic        hv_on_irq,
    input  logic        hv_on_rst,
    input  logic        stop_mode,
    input  logic        wait_mode,
    output logic        cop_rst_req
);
    localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic             hit, svc, dis;
    logic             run_en, pre_clr, cnt_clr, tick, last, live;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    cop_state_t       state;

    // bus decode: reads see the vector byte, writes service the counter
    assign hit       = (bus_addr == COP_SVC_ADDR);
    assign svc       = hit && bus_wr;
    assign bus_rdata = hit ? VEC_LO : 8'h00;

    // mode-dependent disable
    assign dis = (mon_mode && (hv_on_irq || hv_on_rst)) || (brk_active && hv_on_rst);

    cop_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .dis     (dis),
        .stop    (stop_mode),
        .doze    (wait_mode),
        .svc     (svc),
        .last    (last),
        .run_en  (run_en),
        .pre_clr (pre_clr),
        .cnt_clr (cnt_clr),
        .req     (cop_rst_req),
        .live    (live),
        .state_o (state)
    );

    cop_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .en    (run_en),
        .pre_q (pre_q),
        .tick  (tick)
    );

    cop_timeout_counter #(
        .CNT_W       (CNT_W),
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .tick     (tick),
        .rate_sel (rate_sel),
        .cnt_q    (cnt_q),
        .last     (last)
    );

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cop_rst_req |=> !cop_rst_req); // R3

    AST_FIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cop_rst_req) |-> $past(last)); // R2

    AST_SVC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(svc) |-> (cnt_q == '0 && pre_q == '0)); // R4

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dis) |-> (!cop_rst_req && cnt_q == '0 && pre_q == '0)); // R6

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_mode && !dis && !svc && live) |-> ($stable(cnt_q) && pre_q == '0)); // R9

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPENT) |=> (state == ST_SPENT)); // R3
endmodule

// File: tb/cop_watchdog_test.sv
module cop_watchdog_test;
    localparam int         PW  = 2;
    localparam int         P   = 1 << PW;
    localparam int         LT  = 12;
    localparam int         ST  = 5;
    localparam logic [7:0] VEC = 8'hC3;
    localparam int T_LONG  = LT * P;
    localparam int T_SHORT = ST * P;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        rate_sel = 1'b1;
    logic        mon_mode = 1'b0, brk_active = 1'b0, hv_on_irq = 1'b0, hv_on_rst = 1'b0;
    logic        stop_mode = 1'b0, wait_mode = 1'b0;
    logic        cop_rst_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cop_watchdog #(
        .PRE_W(PW), .LONG_TICKS(LT), .SHORT_TICKS(ST), .VEC_LO(VEC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata), .rate_sel(rate_sel), .mon_mode(mon_mode),
        .brk_active(brk_active), .hv_on_irq(hv_on_irq), .hv_on_rst(hv_on_rst),
        .stop_mode(stop_mode), .wait_mode(wait_mode), .cop_rst_req(cop_rst_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cop_rst_req == 1'b0, "R1 request low in reset", cop_rst_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // called at the negedge right after the start event; request expected after n edges
    task automatic expect_fire(input int n, input string tag);
        for (int i = 1; i <= n + 3; i++) begin
            @(negedge clk);
            chk(cop_rst_req == (i == n), tag, cop_rst_req, (i == n));
        end
    endtask

    task automatic bus_write(input logic [15:0] a);
        bus_addr = a;
        bus_wr   = 1'b1;
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = 16'h0000;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R5 read during reset
        bus_addr = 16'hFFFF;
        #1;
        chk(bus_rdata == VEC, "R5 vector read in reset", bus_rdata, VEC);
        bus_addr = 16'h0000;

        // R1 / R2 / R3: reset release starts a full period, single pulse, then silence
        for (int r = 0; r < 2; r++) begin
            rate_sel = r[0];
            do_reset();
            expect_fire(r ? T_SHORT : T_LONG, "R1 R2 timeout from reset");
            for (int i = 0; i < 3 * T_LONG; i++) begin
                @(negedge clk);
                chk(cop_rst_req == 1'b0, "R3 no repeat before reset", cop_rst_req, 0);
            end
        end

        // R4: service at several offsets, both rates
        for (int r = 0; r < 2; r++) begin
            for (int d = 0; d < 2 * P + 3; d++) begin
                rate_sel = r[0];
                do_reset();
                idle(d);
                bus_write(16'hFFFF);
                expect_fire(r ? T_SHORT : T_LONG, "R4 R2 fresh period after service");
            end
        end

        // R4: writes elsewhere are ignored
        rate_sel = 1'b1;
        do_reset();
        idle(5);
        bus_write(16'hFFFE);
        expect_fire(T_SHORT - 6, "R4 other address ignored");
        do_reset();
        idle(3);
        bus_write(16'h7FFF);
        expect_fire(T_SHORT - 4, "R4 other address ignored");

        // R5: reads while counting
        do_reset();
        for (int i = 0; i < 8; i++) begin
            bus_addr = 16'hFFFF;
            #1;
            chk(bus_rdata == VEC, "R5 vector read", bus_rdata, VEC);
            bus_addr = 16'h1234 + 16'(i);
            #1;
            chk(bus_rdata == 8'h00, "R5 other read zero", bus_rdata, 0);
            @(negedge clk);
        end
        bus_addr = 16'h0000;

        // R6 / R7: exhaustive sweep of mode combinations
        for (int m = 0; m < 16; m++) begin
            bit dexp;
            rate_sel   = 1'b1;
            mon_mode   = m[0];
            brk_active = m[1];
            hv_on_irq  = m[2];
            hv_on_rst  = m[3];
            dexp = (m[0] && (m[2] || m[3])) || (m[1] && m[3]);
            do_reset();
            if (dexp) begin
                for (int i = 0; i < 2 * T_SHORT; i++) begin
                    @(negedge clk);
                    chk(cop_rst_req == 1'b0, "R6 R7 disabled no request", cop_rst_req, 0);
                end
                mon_mode = 0; brk_active = 0; hv_on_irq = 0; hv_on_rst = 0;
                expect_fire(T_SHORT, "R6 R7 full period after enable");
            end else begin
                expect_fire(T_SHORT, "R6 R7 enabled combination times out");
            end
        end
        mon_mode = 0; brk_active = 0; hv_on_irq = 0; hv_on_rst = 0;

        // R8: wait mode keeps counting, also when toggled mid-period
        wait_mode = 1'b1;
        do_reset();
        expect_fire(T_SHORT, "R8 wait mode timeout");
        do_reset();
        idle(7);
        wait_mode = 1'b0;
        idle(4);
        wait_mode = 1'b1;
        expect_fire(T_SHORT - 11, "R8 wait toggle no effect");
        wait_mode = 1'b0;

        // R9: stop entered at every offset in the first periods
        for (int k = 0; k < 3 * P; k++) begin
            rate_sel = 1'b1;
            do_reset();
            idle(k);
            stop_mode = 1'b1;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                chk(cop_rst_req == 1'b0, "R9 quiet in stop", cop_rst_req, 0);
            end
            stop_mode = 1'b0;
            expect_fire(T_SHORT - P * (k / P), "R9 resume after stop");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule